// File: doc/BRIEF.md
# Scan Shift Transition Profiler

This block models a single scan chain of `N` cells while one test pattern is applied. A start pulse loads the chain's current contents, the new stimulus and the stimulus's expected response. The block then shifts the stimulus in serially. At the same time the old contents move out at the far end. On every shift cycle it reports how many scan cells changed value. This count is a cycle-accurate proxy for shift power.

After `N` shift cycles it reports one more count for the capture cycle. That count is the number of bit positions in which the stimulus and its expected response differ. A pattern therefore yields `N+1` counts. Test-ordering tools and power-budget monitors use this sequence to judge how flat the per-cycle activity is. For several chains, one instance runs per chain, each on its own.

Top module: `scan_toggle_profiler`

## Requirements
- R1: After reset `cnt_valid`, `cnt_capture` and `pat_done` are low and `toggle_cnt` is 0. The chain model holds all zeros.
- R2: A `start` sampled high while the block is idle loads `chain_in`, `stim` and `resp`. The first shift count appears on the cycle after that edge, with `cnt_valid` high.
- R3: On each shift, cell 1 (bit 0 of the chain) takes the next stimulus bit and every cell i (bit i-1) takes the old value of cell i-1. Stimulus bits enter most significant bit first, so after `N` shifts the chain equals `stim`.
- R4: For `N` consecutive cycles, `toggle_cnt` equals the number of chain bits that differ between the states before and after that cycle's shift. It is never above `N`, and `cnt_capture` stays low during these cycles.
- R5: The cycle after the last shift count, `toggle_cnt` equals the Hamming distance between `stim` and `resp`. In that cycle `cnt_valid`, `cnt_capture` and `pat_done` are all high.
- R6: A `start` pulse while a pattern is in progress, up to and including the capture cycle, is ignored. The count sequence still uses the loaded data, and no second run follows.
- R7: `toggle_cnt` is ceil(log2(N+1)) bits wide, registered, and reads 0 whenever `cnt_valid` is low.
- R8: The cycle after `pat_done`, `cnt_valid` is low. A new pattern can be started from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pattern (honoured only when idle) |
| chain_in | input | N | Chain contents before the pattern (previous response) |
| stim | input | N | Stimulus to shift in, MSB first |
| resp | input | N | Expected response to `stim` |
| toggle_cnt | output | ceil(log2(N+1)) | Toggle count for the reported cycle |
| cnt_valid | output | 1 | `toggle_cnt` is meaningful this cycle |
| cnt_capture | output | 1 | The count belongs to the capture cycle |
| pat_done | output | 1 | Pattern finished (with the capture count) |

## Verification
A six-cell chain is run with every combination of 64 starting chain states and 64 stimuli. The response is varied with each pair, so shift counts range from zero to all cells, and capture distances cover the whole range. A single-one stimulus loaded into an empty chain gives the sequence 1,2,2,2,2,2 under the specified bit order. The reversed order would give 0,0,0,0,0,1, so this pattern detects a reversed entry order or direction. Responses equal to the stimulus and its full complement pin the capture count at 0 and at `N`. A run with `start` held high mid-pattern, with different data on the inputs, shows whether an in-progress pattern can be disturbed or restarted.

// File: rtl/scan_toggle_profiler.sv
module scan_toggle_profiler #(
  parameter int N = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [N-1:0]               chain_in,
  input  logic [N-1:0]               stim,
  input  logic [N-1:0]               resp,
  output logic [$clog2(N+1)-1:0]     toggle_cnt,
  output logic                       cnt_valid,
  output logic                       cnt_capture,
  output logic                       pat_done
);
  localparam int CW = $clog2(N+1);
  localparam int KW = $clog2(N+2);

  logic          busy;
  logic [KW-1:0] step;
  logic [N-1:0]  chain, feed, stim_q, resp_q;
  logic [N-1:0]  chain_nx;

  function automatic logic [CW-1:0] ones(input logic [N-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < N; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  assign chain_nx = {chain[N-2:0], feed[N-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      step        <= '0;
      chain       <= '0;
      feed        <= '0;
      stim_q      <= '0;
      resp_q      <= '0;
      toggle_cnt  <= '0;
      cnt_valid   <= 1'b0;
      cnt_capture <= 1'b0;
      pat_done    <= 1'b0;
    end else begin
      toggle_cnt  <= '0;
      cnt_valid   <= 1'b0;
      cnt_capture <= 1'b0;
      pat_done    <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          step   <= '0;
          chain  <= chain_in;
          feed   <= stim;
          stim_q <= stim;
          resp_q <= resp;
        end
      end else if (step < KW'(N)) begin
        chain      <= chain_nx;
        feed       <= feed << 1;
        toggle_cnt <= ones(chain ^ chain_nx);
        cnt_valid  <= 1'b1;
        step       <= step + KW'(1);
      end else begin
        toggle_cnt  <= ones(stim_q ^ resp_q);
        cnt_valid   <= 1'b1;
        cnt_capture <= 1'b1;
        pat_done    <= 1'b1;
        busy        <= 1'b0;
      end
    end
  end

  assert_capture_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_capture |-> (pat_done && cnt_valid));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid |-> (toggle_cnt <= N));

  assert_shift_inside_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_valid && !cnt_capture) |-> busy);

  assert_pattern_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(stim_q) && $stable(resp_q)));

  assert_gap_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pat_done |=> !cnt_valid);

  assert_quiet_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_valid |-> (toggle_cnt == '0));
endmodule

// File: tb/scan_toggle_profiler_test.sv
module scan_toggle_profiler_test;
  localparam int N = 6;
  localparam int CW = $clog2(N+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] chain_in = '0, stim = '0, resp = '0;
  logic [CW-1:0] toggle_cnt;
  logic cnt_valid, cnt_capture, pat_done;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  scan_toggle_profiler #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_in(chain_in),
    .stim(stim), .resp(resp), .toggle_cnt(toggle_cnt), .cnt_valid(cnt_valid),
    .cnt_capture(cnt_capture), .pat_done(pat_done)
  );

  function automatic int pc(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) if (v[i]) c++;
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_pat(input logic [N-1:0] ci, input logic [N-1:0] st,
                         input logic [N-1:0] rs, input bit poke, input string tag);
    logic [N-1:0] c, nc;
    @(negedge clk);
    chain_in = ci; stim = st; resp = rs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = ci;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      nc = {c[N-2:0], st[N-1-k]};
      check(cnt_valid && !cnt_capture && !pat_done, {tag, " R2 shift flags"},
            {cnt_valid, cnt_capture, pat_done}, 3'b100);
      check(toggle_cnt == CW'(pc(c ^ nc)), {tag, " R4 shift count"},
            toggle_cnt, pc(c ^ nc));
      c = nc;
      if (poke && k == 1) begin
        start = 1'b1; chain_in = ~ci; stim = ~st; resp = st;
      end
    end
    @(negedge clk);
    check(cnt_valid && cnt_capture && pat_done, {tag, " R5 capture flags"},
          {cnt_valid, cnt_capture, pat_done}, 3'b111);
    check(toggle_cnt == CW'(pc(st ^ rs)), {tag, " R5 capture count"},
          toggle_cnt, pc(st ^ rs));
    start = 1'b0;
    @(negedge clk);
    check(!cnt_valid && !pat_done && toggle_cnt == 0, {tag, " R8/R6 idle after done"},
          {cnt_valid, pat_done}, 0);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!cnt_valid && !cnt_capture && !pat_done && toggle_cnt == 0, "R1 reset outputs",
          {cnt_valid, cnt_capture, pat_done, toggle_cnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cnt_valid && toggle_cnt == 0, "R7 idle count zero", toggle_cnt, 0);

    // R3: single one into empty chain, MSB first, entering at bit 0
    run_pat('0, 6'b100000, 6'b100000, 1'b0, "R3 order");
    // R5 extremes
    run_pat(6'b101110, 6'b110110, 6'b110110, 1'b0, "R5 zero distance");
    run_pat(6'b010101, 6'b110010, 6'b001101, 1'b0, "R5 full distance");
    // R6: start held mid-pattern with other data
    run_pat(6'b011001, 6'b100111, 6'b111100, 1'b1, "R6 busy start");
    // R4 sweep over all chain states and stimuli
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++)
        run_pat(N'(a), N'(b), N'(a) ^ N'(b) ^ N'(b >> 2), 1'b0, "R4 sweep");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule